// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a bus target that keeps a small bank of byte-wide configuration registers and lets a host reach them over a two-wire SMBus/I2C link. Both bus lines are sampled from the pads. Each line passes through a synchronizer and a sample filter. The target pulls SDA low through an open-drain enable and never drives SCL. Every register is also presented on a wide parallel output, so neighbouring logic can use the settings directly.

A host writes by sending the target's write address, a starting index, a byte count and then the data bytes. These land in consecutive registers. To read, the host sends the write address and the index, then issues a repeated start with the read address. The target answers first with the contents of a dedicated count register, then streams registers from the chosen index. It keeps doing so for as long as the host acknowledges. The register pointer steps after every data byte and wraps around the end of the bank.

Top module: `smb_idx_target`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (write) and 0xD3 (read), i.e. 7-bit address 0x69 with the R/W bit in bit 0, by holding SDA low during the ninth clock.
- R2: For any other address byte the target gives no acknowledge, leaves SDA released and ignores all bytes until the next start; no register changes.
- R3: In a write transfer the byte after the address is the start index, the next byte is the count, and each following byte is stored at the pointer; the pointer advances after each store and every byte is acknowledged.
- R4: In a read transfer, after the repeated start and read address, the first byte sent is the value of register 8, followed by registers from the start index upward; bits go out most significant first.
- R5: When the host answers a read byte with a NACK, the target stops driving SDA for the rest of the transfer, even if fewer bytes than the count were sent.
- R6: The start index is taken modulo 16 (its low four bits), and the pointer wraps from 15 to 0 on both writes and reads.
- R7: A stop or start in the middle of a byte aborts the transfer; the partially received byte is not stored and SDA is released.
- R8: Data bytes beyond the declared count are still acknowledged and stored at the advancing pointer until stop.
- R9: The target changes its SDA drive only while SCL is low.
- R10: Pulses on SCL or SDA that last fewer than three clock samples are ignored.
- R11: After reset all registers read 0x00 and SDA is released.
- R12: Register i appears on bits [8i+7:8i] of the parallel output and changes only when a data byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock sampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREG*8 | All registers, register i at bits [8i+7:8i] |

## Verification
The bench builds the target with its defaults: a 16-entry bank, address 0x69, count register at index 8, two synchronizer stages and a three-sample filter. A bank of 16 puts the wrap from 15 to 0 within reach, and an index byte of 0x1F exercises the modulo on the index. A three-sample filter makes a two-cycle pulse the longest glitch that must be rejected, and the bench injects exactly that on both lines. The bit quarter-period of 12 clocks exceeds the eight-cycle path from the pad to the SDA drive. The target's drive changes therefore fall inside the low phase of SCL, where R9 can be observed.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_DATA
  } smb_phase_e;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 3,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_STAGES{IDLE_LVL}};
      hist_q <= {FILT_LEN{IDLE_LVL}};
      out_q  <= IDLE_LVL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        out_q <= 1'b1;
      else if (~|hist_q)
        out_q <= 1'b0;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int NREG    = 16,
  parameter int CNT_IDX = 8,
  localparam int PW     = $clog2(NREG),
  localparam int BW     = smb_idx_pkg::BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [BW-1:0]    wr_data,
  input  logic [PW-1:0]    rd_idx,
  output logic [BW-1:0]    rd_data,
  output logic [BW-1:0]    cnt_data,
  output logic [NREG*BW-1:0] regs_o
);
  localparam logic [PW-1:0] CNT_SEL = PW'(CNT_IDX);

  logic [BW-1:0] mem_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data  = mem_q[rd_idx];
  assign cnt_data = mem_q[CNT_SEL];

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*BW +: BW] = mem_q[g];
  end
endmodule

// File: rtl/smb_idx_fsm.sv
module smb_idx_fsm
  import smb_idx_pkg::*;
#(
  parameter int         NREG  = 16,
  parameter logic [6:0] ADDR7 = 7'h69,
  localparam int        PW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] cnt_data,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PW-1:0]     ptr,
  output logic [BYTE_W-1:0] wr_data
);
  smb_state_e        state_q;
  smb_phase_e        phase_q;
  logic [3:0]        bitcnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [PW-1:0]     ptr_q;
  logic              oe_q;
  logic              go_tx_q;
  logic              acked_q;
  logic              byte_done;

  assign byte_done = scl_fall && (state_q == ST_RX) && (bitcnt_q == 4'd8);
  assign wr_en     = byte_done && (phase_q == PH_DATA) && !start_det && !stop_det;
  assign wr_data   = sh_q;
  assign ptr       = ptr_q;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      sh_q     <= '0;
      ptr_q    <= '0;
      oe_q     <= 1'b0;
      go_tx_q  <= 1'b0;
      acked_q  <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      go_tx_q <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_RX;
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
      go_tx_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && bitcnt_q < 4'd8) begin
            sh_q     <= {sh_q[BYTE_W-2:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (byte_done) begin
            unique case (phase_q)
              PH_ADDR: begin
                if (sh_q[BYTE_W-1:1] == ADDR7) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_RXACK;
                  go_tx_q <= sh_q[0];
                  phase_q <= PH_INDEX;
                end else begin
                  state_q <= ST_WAIT;
                end
              end
              PH_INDEX: begin
                ptr_q   <= sh_q[PW-1:0];
                oe_q    <= 1'b1;
                state_q <= ST_RXACK;
                phase_q <= PH_COUNT;
              end
              PH_COUNT: begin
                oe_q    <= 1'b1;
                state_q <= ST_RXACK;
                phase_q <= PH_DATA;
              end
              default: begin
                ptr_q   <= ptr_q + PW'(1);
                oe_q    <= 1'b1;
                state_q <= ST_RXACK;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            if (go_tx_q) begin
              go_tx_q <= 1'b0;
              sh_q    <= cnt_data;
              oe_q    <= ~cnt_data[BYTE_W-1];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && bitcnt_q < 4'd8) begin
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              acked_q <= 1'b0;
              state_q <= ST_TXACK;
            end else begin
              oe_q <= ~sh_q[BYTE_W-2];
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            if (!sda_lvl) acked_q <= 1'b1;
            else          state_q <= ST_WAIT;
          end else if (scl_fall && acked_q) begin
            acked_q  <= 1'b0;
            sh_q     <= rd_data;
            oe_q     <= ~rd_data[BYTE_W-1];
            ptr_q    <= ptr_q + PW'(1);
            bitcnt_q <= '0;
            state_q  <= ST_TX;
          end
        end
        default: begin
          oe_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/smb_idx_target.sv
module smb_idx_target
  import smb_idx_pkg::*;
#(
  parameter int         NREG        = 16,
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         CNT_IDX     = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  localparam int        PW          = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  logic [1:0]        line_raw;
  logic [1:0]        line_flt;
  logic              scl_flt, sda_flt;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PW-1:0]     ptr;
  logic [BYTE_W-1:0] wr_data, rd_data, cnt_data;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .IDLE_LVL   (1'b1)
    ) u_flt (
      .clk (clk),
      .rst (rst),
      .din (line_raw[g]),
      .dout(line_flt[g])
    );
  end

  assign scl_flt = line_flt[0];
  assign sda_flt = line_flt[1];

  smb_bus_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_flt),
    .sda_f    (sda_flt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  smb_idx_fsm #(
    .NREG (NREG),
    .ADDR7(ADDR7)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sda_lvl  (sda_flt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .cnt_data (cnt_data),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .ptr      (ptr),
    .wr_data  (wr_data)
  );

  smb_reg_bank #(
    .NREG   (NREG),
    .CNT_IDX(CNT_IDX)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (ptr),
    .wr_data (wr_data),
    .rd_idx  (ptr),
    .rd_data (rd_data),
    .cnt_data(cnt_data),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/smb_idx_target_chk.sv
module smb_idx_target_chk #(
  parameter int NREG = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            scl_f,
  input logic            sda_oe,
  input logic            start_det,
  input logic            stop_det,
  input logic            wr_en,
  input logic [NREG*8-1:0] regs_o
);
  // R9: drive changes only while filtered SCL is low
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f);

  // R7: a stop releases SDA
  a_r7_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R7: a start releases SDA
  a_r7_start_release: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R12: registers hold unless a byte is stored
  a_r12_regs_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_o));

  // R3: bytes are stored only in the low phase of SCL
  a_r3_store_scl_low: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !scl_f);
endmodule

bind smb_idx_target smb_idx_target_chk #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_f    (scl_flt),
  .sda_oe   (sda_oe),
  .start_det(start_det),
  .stop_det (stop_det),
  .wr_en    (wr_en),
  .regs_o   (regs_o)
);

// File: tb/smb_idx_target_bench.sv
module smb_idx_target_bench;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [16*8-1:0] regs_o;
  wire  sda_bus = sda_h & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int r9_viol = 0;
  bit live = 1'b0;
  logic [7:0] wb [8];

  always #5 clk = ~clk;

  smb_idx_target u_smb_idx_target (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_h),
    .sda_i (sda_bus),
    .sda_oe(sda_oe),
    .regs_o(regs_o)
  );

  always @(sda_oe) if (live && scl_h) r9_viol++;

  function automatic logic [7:0] rg(input int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_start;
    sda_h = 1'b1; wq(Q);
    scl_h = 1'b1; wq(Q);
    sda_h = 1'b0; wq(Q);
    scl_h = 1'b0; wq(Q);
  endtask

  task automatic h_stop;
    sda_h = 1'b0; wq(Q);
    scl_h = 1'b1; wq(Q);
    sda_h = 1'b1; wq(2*Q);
  endtask

  task automatic h_bit(input bit b);
    sda_h = b;    wq(Q);
    scl_h = 1'b1; wq(2*Q);
    scl_h = 1'b0; wq(Q);
  endtask

  // two-cycle pulses on SCL (low phase) and on SDA (high phase)
  task automatic h_bit_glitch(input bit b);
    sda_h = b;    wq(3);
    scl_h = 1'b1; wq(2);
    scl_h = 1'b0; wq(Q-5);
    scl_h = 1'b1; wq(6);
    sda_h = ~b;   wq(2);
    sda_h = b;    wq(2*Q-8);
    scl_h = 1'b0; wq(Q);
  endtask

  task automatic h_wbyte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      if (glitch) h_bit_glitch(b[i]);
      else        h_bit(b[i]);
    end
    sda_h = 1'b1; wq(Q);
    scl_h = 1'b1; wq(Q);
    ack = !sda_bus; wq(Q);
    scl_h = 1'b0; wq(Q);
  endtask

  task automatic h_rbyte(input bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1'b1; wq(Q);
      scl_h = 1'b1; wq(Q);
      d[i] = sda_bus; wq(Q);
      scl_h = 1'b0; wq(Q);
    end
    h_bit(!give_ack);
  endtask

  task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt, input int n, input string tag);
    bit a;
    h_start;
    h_wbyte(8'hD2, 1'b0, a); chk(a, "R1 write address ack", a, 1);
    h_wbyte(idx, 1'b0, a);   chk(a, {tag, " index ack"}, a, 1);
    h_wbyte(cnt, 1'b0, a);   chk(a, {tag, " count ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      h_wbyte(wb[i], 1'b0, a); chk(a, {tag, " data ack"}, a, 1);
    end
    h_stop;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) chk(rg(i) == 8'h00, "R11 register reset", rg(i), 0);
    chk(sda_oe == 1'b0, "R11 SDA released", sda_oe, 0);
  endtask

  task automatic t_write_basic;
    wb[0] = 8'hA1; wb[1] = 8'hB2; wb[2] = 8'hC3;
    blk_write(8'h02, 8'h03, 3, "R3");
    chk(regs_o[23:16] == 8'hA1, "R12 reg2 field", regs_o[23:16], 8'hA1);
    chk(rg(3) == 8'hB2, "R3 reg3", rg(3), 8'hB2);
    chk(rg(4) == 8'hC3, "R3 reg4", rg(4), 8'hC3);
    chk(rg(5) == 8'h00, "R12 reg5 untouched", rg(5), 0);
  endtask

  task automatic t_set_count;
    wb[0] = 8'h04;
    blk_write(8'h08, 8'h01, 1, "R4");
    chk(rg(8) == 8'h04, "R4 count register", rg(8), 8'h04);
  endtask

  task automatic t_wrap_write;
    wb[0] = 8'h5A; wb[1] = 8'h6B;
    blk_write(8'h1F, 8'h02, 2, "R6");
    chk(rg(15) == 8'h5A, "R6 index modulo", rg(15), 8'h5A);
    chk(rg(0) == 8'h6B, "R6 write wrap", rg(0), 8'h6B);
  endtask

  task automatic t_read_short;
    bit a; logic [7:0] d;
    h_start;
    h_wbyte(8'hD2, 1'b0, a); chk(a, "R1 write address ack", a, 1);
    h_wbyte(8'h02, 1'b0, a); chk(a, "R4 index ack", a, 1);
    h_start;
    h_wbyte(8'hD3, 1'b0, a); chk(a, "R1 read address ack", a, 1);
    h_rbyte(1'b1, d); chk(d == 8'h04, "R4 count byte first", d, 8'h04);
    h_rbyte(1'b1, d); chk(d == 8'hA1, "R4 data at index", d, 8'hA1);
    h_rbyte(1'b0, d); chk(d == 8'hB2, "R4 next data", d, 8'hB2);
    h_rbyte(1'b0, d); chk(d == 8'hFF, "R5 released after NACK", d, 8'hFF);
    chk(sda_oe == 1'b0, "R5 no drive after NACK", sda_oe, 0);
    h_stop;
  endtask

  task automatic t_read_wrap;
    bit a; logic [7:0] d;
    h_start;
    h_wbyte(8'hD2, 1'b0, a); chk(a, "R6 address ack", a, 1);
    h_wbyte(8'h0E, 1'b0, a); chk(a, "R6 index ack", a, 1);
    h_start;
    h_wbyte(8'hD3, 1'b0, a); chk(a, "R6 read address ack", a, 1);
    h_rbyte(1'b1, d); chk(d == 8'h04, "R6 count byte", d, 8'h04);
    h_rbyte(1'b1, d); chk(d == 8'h00, "R6 reg14", d, 8'h00);
    h_rbyte(1'b1, d); chk(d == 8'h5A, "R6 reg15", d, 8'h5A);
    h_rbyte(1'b0, d); chk(d == 8'h6B, "R6 read wrap to reg0", d, 8'h6B);
    h_stop;
  endtask

  task automatic t_bad_addr;
    bit a;
    h_start;
    h_wbyte(8'hA4, 1'b0, a); chk(!a, "R2 foreign address not acked", a, 0);
    h_wbyte(8'h03, 1'b0, a); chk(!a, "R2 later byte ignored", a, 0);
    h_wbyte(8'h01, 1'b0, a); chk(!a, "R2 later byte ignored", a, 0);
    h_wbyte(8'h77, 1'b0, a); chk(!a, "R2 later byte ignored", a, 0);
    h_stop;
    chk(rg(3) == 8'hB2, "R2 register unchanged", rg(3), 8'hB2);
  endtask

  task automatic t_overrun;
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33;
    blk_write(8'h0A, 8'h01, 3, "R8");
    chk(rg(10) == 8'h11, "R8 first byte", rg(10), 8'h11);
    chk(rg(11) == 8'h22, "R8 beyond count", rg(11), 8'h22);
    chk(rg(12) == 8'h33, "R8 beyond count", rg(12), 8'h33);
  endtask

  task automatic t_abort;
    bit a;
    h_start;
    h_wbyte(8'hD2, 1'b0, a); h_wbyte(8'h06, 1'b0, a); h_wbyte(8'h01, 1'b0, a);
    for (int i = 0; i < 4; i++) h_bit(1'b1);
    h_stop;
    chk(rg(6) == 8'h00, "R7 stop mid byte", rg(6), 0);
    chk(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);
    h_start;
    h_wbyte(8'hD2, 1'b0, a); h_wbyte(8'h07, 1'b0, a); h_wbyte(8'h01, 1'b0, a);
    for (int i = 0; i < 3; i++) h_bit(1'b1);
    h_start;
    h_wbyte(8'hD2, 1'b0, a); chk(a, "R7 new transfer address ack", a, 1);
    h_wbyte(8'h09, 1'b0, a); h_wbyte(8'h01, 1'b0, a);
    h_wbyte(8'h99, 1'b0, a); chk(a, "R7 new transfer data ack", a, 1);
    h_stop;
    chk(rg(7) == 8'h00, "R7 start mid byte", rg(7), 0);
    chk(rg(9) == 8'h99, "R7 transfer after restart", rg(9), 8'h99);
  endtask

  task automatic t_glitch;
    bit a;
    h_start;
    h_wbyte(8'hD2, 1'b1, a); chk(a, "R10 address ack with glitches", a, 1);
    h_wbyte(8'h0D, 1'b1, a); chk(a, "R10 index ack with glitches", a, 1);
    h_wbyte(8'h01, 1'b0, a);
    h_wbyte(8'h3C, 1'b1, a); chk(a, "R10 data ack with glitches", a, 1);
    h_stop;
    chk(rg(13) == 8'h3C, "R10 glitches ignored", rg(13), 8'h3C);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wq(5);
    rst = 1'b0;
    wq(20);
    live = 1'b1;
    t_reset;
    t_write_basic;
    t_set_count;
    t_wrap_write;
    t_read_short;
    t_read_wrap;
    t_bad_addr;
    t_overrun;
    t_abort;
    t_glitch;
    chk(r9_viol == 0, "R9 drive changed while SCL high", r9_viol, 0);
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run;
  end
endmodule